// File: doc/BRIEF.md
# I2C EEPROM Address-Width Probe

This block finds out whether a serial EEPROM at a given 7-bit I2C target address expects one or two bytes of memory addressing. It does not toggle SCL or SDA. Instead it sends a stream of byte-level commands to an I2C master engine and consumes one response for each command. After a one-cycle `start` pulse it runs eight probe reads. It compares the eight bytes it reads back and reports the result on `two_byte`, together with a one-cycle `done` pulse. If the target refuses any address or write byte, the block closes the bus with a STOP and reports `error` in place of a result.

There are two probe methods, chosen by `legacy_mode` when `start` is accepted. In the default (compliant) method, every probe writes a two-byte pointer and then reads through a repeated START, with no STOP in between. A one-byte-address device therefore takes the second pointer byte as pending data. That data is dropped at the repeated START and never committed. In the legacy method, one pointer byte is written and closed with STOP, and eight standalone single-byte reads follow.

The command stream is valid/ready. The block raises `cmd_valid` with `cmd_op` and `cmd_data` and holds all three unchanged until `cmd_ready` is seen high on a clock edge. Only one command is ever outstanding: the next command is offered only after the engine has returned `rsp_valid` for the previous one. There is no back-pressure on responses. A `rsp_valid` cycle is always consumed when it arrives.

Top module: `eeprom_addr_probe`

## Requirements
- R1: In compliant mode (`legacy_mode`=0) the block issues exactly 8 probes. Probe k (k = 0..7) is the sequence START, WRITE {target,0}, WRITE 0x00, WRITE k, RESTART, WRITE {target,1}, READ_NACK, STOP. Command codes on `cmd_op` are START=0, RESTART=1, STOP=2, WRITE=3, READ_ACK=4, READ_NACK=5. An address byte is the 7-bit target in bits 7:1 with the read flag in bit 0 (write=0, read=1).
- R2: A STOP is never accepted between the last pointer byte of a probe and its repeated START. Every accepted RESTART directly follows an accepted WRITE, and no probe makes a one-byte-address device commit a write.
- R3: If all 8 captured read bytes are equal, `two_byte` is 0. If any one of them differs, including only the first or only the last, `two_byte` is 1.
- R4: In legacy mode (`legacy_mode`=1) the block issues START, WRITE {target,0}, WRITE 0x00, STOP. It then issues 8 reads, each START, WRITE {target,1}, READ_NACK, STOP. The result follows the same rule as R3.
- R5: A two-byte device whose probed locations all hold the same value is reported with `two_byte`=0 and `error`=0.
- R6: Every data read is requested as READ_NACK. READ_ACK is never issued.
- R7: If `rsp_ack` is 0 in the response to any WRITE, the block issues one STOP, ends the run, and pulses `done` with `error`=1 and `two_byte`=0.
- R8: `busy` rises on the cycle after an accepted `start`. It stays high until the cycle in which `done` is high, and at that point it is already low. A `start` while `busy` is ignored, and `cmd_valid` is never high while `busy` is low.
- R9: `done` is high for exactly one cycle per run. `two_byte` and `error` keep their values until the next accepted `start`. After reset, `busy`, `done`, `two_byte`, `error` and `cmd_valid` are 0.
- R10: Once raised, `cmd_valid` stays high with `cmd_op` and `cmd_data` stable until `cmd_ready`. No new command is offered while a response is still awaited.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Run request pulse, accepted only while idle |
| target_addr | input | ADDR_W | 7-bit I2C target address of the EEPROM |
| legacy_mode | input | 1 | 1 selects the STOP-terminated legacy method |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| two_byte | output | 1 | 1 when two-byte addressing was detected |
| error | output | 1 | 1 when the last run ended on a refused byte |
| cmd_valid | output | 1 | Command offered to the master engine |
| cmd_ready | input | 1 | Engine accepts the offered command |
| cmd_op | output | 3 | Command code (see R1) |
| cmd_data | output | DATA_W | Byte to send for WRITE commands |
| rsp_valid | input | 1 | Engine has completed the accepted command |
| rsp_ack | input | 1 | Target acknowledged the written byte |
| rsp_data | input | DATA_W | Byte returned by a read command |

## Verification
The bound checker watches the handshake rules on every cycle: command hold under back-pressure, the single outstanding command, and the rule that a repeated START always follows a write. It also checks on every cycle that no read asks for an ACK, the `busy`/`done` relation, the one-cycle `done`, the results held while idle, and the clean result after an abort. Only the bench scenarios can show that the command order and pointer bytes are exact, that a behavioural EEPROM model never commits a write, and that the classification is right. The bench covers first-only and last-only mismatches, uniform memory, non-incrementing two-byte devices in both methods, and refusals at the address byte, at a pointer byte and in a later probe.

// File: rtl/eap_pkg.sv
package eap_pkg;

  typedef enum logic [2:0] {
    OP_START     = 3'd0,
    OP_RESTART   = 3'd1,
    OP_STOP      = 3'd2,
    OP_WRITE     = 3'd3,
    OP_READ_ACK  = 3'd4,
    OP_READ_NACK = 3'd5
  } eap_op_e;

  localparam int unsigned STEP_W = 3;

endpackage

// File: rtl/eap_step_gen.sv
// Decodes (method, phase, probe index, step) into the command to send next.
module eap_step_gen
  import eap_pkg::*;
#(
  parameter int unsigned ADDR_W  = 7,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned PROBE_W = 3
) (
  input  logic               legacy,
  input  logic               preamble,
  input  logic [PROBE_W-1:0] probe,
  input  logic [STEP_W-1:0]  step,
  input  logic [ADDR_W-1:0]  target,
  output eap_op_e            op,
  output logic [DATA_W-1:0]  data,
  output logic               last
);

  logic [DATA_W-1:0] wr_byte;
  logic [DATA_W-1:0] rd_byte;

  assign wr_byte = DATA_W'({target, 1'b0});
  assign rd_byte = DATA_W'({target, 1'b1});

  always_comb begin
    op   = OP_STOP;
    data = '0;
    last = 1'b0;
    if (!legacy) begin
      // pointer-then-combined-read probe, eight steps
      unique case (step)
        3'd0: op = OP_START;
        3'd1: begin op = OP_WRITE; data = wr_byte; end
        3'd2: begin op = OP_WRITE; data = '0; end
        3'd3: begin op = OP_WRITE; data = DATA_W'(probe); end
        3'd4: op = OP_RESTART;
        3'd5: begin op = OP_WRITE; data = rd_byte; end
        3'd6: op = OP_READ_NACK;
        default: begin op = OP_STOP; last = 1'b1; end
      endcase
    end else if (preamble) begin
      // single pointer byte closed by STOP
      unique case (step)
        3'd0: op = OP_START;
        3'd1: begin op = OP_WRITE; data = wr_byte; end
        3'd2: begin op = OP_WRITE; data = '0; end
        default: begin op = OP_STOP; last = 1'b1; end
      endcase
    end else begin
      // standalone current-address read
      unique case (step)
        3'd0: op = OP_START;
        3'd1: begin op = OP_WRITE; data = rd_byte; end
        3'd2: op = OP_READ_NACK;
        default: begin op = OP_STOP; last = 1'b1; end
      endcase
    end
  end

endmodule

// File: rtl/eap_cmd_port.sv
// Valid/ready command issue with a single outstanding request.
module eap_cmd_port
  import eap_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  eap_op_e           issue_op,
  input  logic [DATA_W-1:0] issue_data,
  output logic              idle,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output eap_op_e           cmd_op,
  output logic [DATA_W-1:0] cmd_data,
  input  logic              rsp_valid,
  input  logic              rsp_ack,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              got_rsp,
  output logic              got_ack,
  output logic [DATA_W-1:0] got_data,
  output eap_op_e           pend_op
);

  typedef enum logic [1:0] {P_EMPTY, P_OFFER, P_WAIT} port_st_e;

  port_st_e          st_q;
  eap_op_e           op_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= P_EMPTY;
      op_q   <= OP_STOP;
      data_q <= '0;
    end else begin
      unique case (st_q)
        P_EMPTY: if (issue) begin
          op_q   <= issue_op;
          data_q <= issue_data;
          st_q   <= P_OFFER;
        end
        P_OFFER: if (cmd_ready) st_q <= P_WAIT;
        P_WAIT:  if (rsp_valid) st_q <= P_EMPTY;
        default: st_q <= P_EMPTY;
      endcase
    end
  end

  assign idle      = (st_q == P_EMPTY);
  assign cmd_valid = (st_q == P_OFFER);
  assign cmd_op    = op_q;
  assign cmd_data  = data_q;
  assign got_rsp   = (st_q == P_WAIT) && rsp_valid;
  assign got_ack   = rsp_ack;
  assign got_data  = rsp_data;
  assign pend_op   = op_q;

endmodule

// File: rtl/eap_cmp.sv
// Running all-equal test: first byte kept as reference, later bytes compared.
module eap_cmp #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              capture,
  input  logic [DATA_W-1:0] din,
  output logic              differ
);

  logic              have_ref_q;
  logic [DATA_W-1:0] ref_q;
  logic              differ_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_ref_q <= 1'b0;
      ref_q      <= '0;
      differ_q   <= 1'b0;
    end else if (clear) begin
      have_ref_q <= 1'b0;
      differ_q   <= 1'b0;
    end else if (capture) begin
      if (!have_ref_q) begin
        ref_q      <= din;
        have_ref_q <= 1'b1;
      end else if (din != ref_q) begin
        differ_q <= 1'b1;
      end
    end
  end

  assign differ = differ_q;

endmodule

// File: rtl/eeprom_addr_probe.sv
module eeprom_addr_probe
  import eap_pkg::*;
#(
  parameter int unsigned ADDR_W     = 7,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned NUM_PROBES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] target_addr,
  input  logic              legacy_mode,
  output logic              busy,
  output logic              done,
  output logic              two_byte,
  output logic              error,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [2:0]        cmd_op,
  output logic [DATA_W-1:0] cmd_data,
  input  logic              rsp_valid,
  input  logic              rsp_ack,
  input  logic [DATA_W-1:0] rsp_data
);

  localparam int unsigned PROBE_W = (NUM_PROBES > 1) ? $clog2(NUM_PROBES) : 1;
  localparam logic [PROBE_W-1:0] LAST_PROBE = PROBE_W'(NUM_PROBES - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_SEND, S_WAIT, S_ABORT_SEND, S_ABORT_WAIT
  } seq_st_e;

  seq_st_e            st_q;
  logic [ADDR_W-1:0]  tgt_q;
  logic               legacy_q;
  logic               pre_q;
  logic [PROBE_W-1:0] probe_q;
  logic [STEP_W-1:0]  step_q;
  logic               done_q;
  logic               two_q;
  logic               err_q;

  eap_op_e            gen_op;
  logic [DATA_W-1:0]  gen_data;
  logic               gen_last;

  logic               port_idle;
  eap_op_e            port_op;
  eap_op_e            pend_op;
  logic               got_rsp;
  logic               got_ack;
  logic [DATA_W-1:0]  got_data;
  logic               cmp_differ;

  logic               accept;
  logic               issue;
  eap_op_e            issue_op;
  logic [DATA_W-1:0]  issue_data;
  logic               capture;
  logic               wr_refused;
  logic               seq_end;

  eap_step_gen #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .PROBE_W(PROBE_W)
  ) u_gen (
    .legacy  (legacy_q),
    .preamble(pre_q),
    .probe   (probe_q),
    .step    (step_q),
    .target  (tgt_q),
    .op      (gen_op),
    .data    (gen_data),
    .last    (gen_last)
  );

  eap_cmd_port #(
    .DATA_W(DATA_W)
  ) u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue     (issue),
    .issue_op  (issue_op),
    .issue_data(issue_data),
    .idle      (port_idle),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_op    (port_op),
    .cmd_data  (cmd_data),
    .rsp_valid (rsp_valid),
    .rsp_ack   (rsp_ack),
    .rsp_data  (rsp_data),
    .got_rsp   (got_rsp),
    .got_ack   (got_ack),
    .got_data  (got_data),
    .pend_op   (pend_op)
  );

  eap_cmp #(
    .DATA_W(DATA_W)
  ) u_cmp (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (accept),
    .capture(capture),
    .din    (got_data),
    .differ (cmp_differ)
  );

  assign accept     = start && (st_q == S_IDLE);
  assign issue      = ((st_q == S_SEND) || (st_q == S_ABORT_SEND)) && port_idle;
  assign issue_op   = (st_q == S_ABORT_SEND) ? OP_STOP : gen_op;
  assign issue_data = (st_q == S_ABORT_SEND) ? '0 : gen_data;
  assign capture    = (st_q == S_WAIT) && got_rsp && (pend_op == OP_READ_NACK);
  assign wr_refused = (pend_op == OP_WRITE) && !got_ack;
  assign seq_end    = gen_last && !pre_q && (probe_q == LAST_PROBE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      tgt_q    <= '0;
      legacy_q <= 1'b0;
      pre_q    <= 1'b0;
      probe_q  <= '0;
      step_q   <= '0;
      done_q   <= 1'b0;
      two_q    <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        S_IDLE: if (accept) begin
          tgt_q    <= target_addr;
          legacy_q <= legacy_mode;
          pre_q    <= legacy_mode;
          probe_q  <= '0;
          step_q   <= '0;
          two_q    <= 1'b0;
          err_q    <= 1'b0;
          st_q     <= S_SEND;
        end
        S_SEND: if (issue) st_q <= S_WAIT;
        S_WAIT: if (got_rsp) begin
          if (wr_refused) begin
            st_q <= S_ABORT_SEND;
          end else if (gen_last) begin
            if (seq_end) begin
              done_q <= 1'b1;
              two_q  <= cmp_differ;
              st_q   <= S_IDLE;
            end else begin
              step_q <= '0;
              if (pre_q) pre_q <= 1'b0;
              else       probe_q <= probe_q + 1'b1;
              st_q <= S_SEND;
            end
          end else begin
            step_q <= step_q + 1'b1;
            st_q   <= S_SEND;
          end
        end
        S_ABORT_SEND: if (issue) st_q <= S_ABORT_WAIT;
        S_ABORT_WAIT: if (got_rsp) begin
          done_q <= 1'b1;
          err_q  <= 1'b1;
          two_q  <= 1'b0;
          st_q   <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy     = (st_q != S_IDLE);
  assign done     = done_q;
  assign two_byte = two_q;
  assign error    = err_q;
  assign cmd_op   = port_op;

endmodule

// File: rtl/eap_chk.sv
module eap_chk
  import eap_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              two_byte,
  input logic              error,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [2:0]        cmd_op,
  input logic [DATA_W-1:0] cmd_data,
  input logic              rsp_valid
);

  logic [2:0] last_acc_q;
  logic       outstanding_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_acc_q    <= 3'(OP_STOP);
      outstanding_q <= 1'b0;
    end else begin
      if (cmd_valid && cmd_ready) begin
        last_acc_q    <= cmd_op;
        outstanding_q <= 1'b1;
      end else if (rsp_valid) begin
        outstanding_q <= 1'b0;
      end
    end
  end

  p_restart_after_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op == 3'(OP_RESTART)) |-> (last_acc_q == 3'(OP_WRITE)));

  p_reads_nack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_op != 3'(OP_READ_ACK)));

  p_abort_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && error) |-> !two_byte);

  p_busy_ends_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cmd_valid);

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_result_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(two_byte) && $stable(error)));

  p_cmd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_data)));

  p_single_outstanding_r10: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding_q |-> !cmd_valid);

endmodule

bind eeprom_addr_probe eap_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .two_byte (two_byte),
  .error    (error),
  .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready),
  .cmd_op   (cmd_op),
  .cmd_data (cmd_data),
  .rsp_valid(rsp_valid)
);

// File: tb/tb_eeprom_addr_probe.sv
module tb_eeprom_addr_probe;

  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] C_START = 3'd0, C_RESTART = 3'd1, C_STOP = 3'd2,
                         C_WRITE = 3'd3, C_RDACK = 3'd4, C_RDNACK = 3'd5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [6:0] target_addr = 7'h50;
  logic       legacy_mode = 1'b0;
  logic       busy, done, two_byte, error;
  logic       cmd_valid;
  logic       cmd_ready = 1'b0;
  logic [2:0] cmd_op;
  logic [7:0] cmd_data;
  logic       rsp_valid = 1'b0;
  logic       rsp_ack = 1'b0;
  logic [7:0] rsp_data = 8'h00;

  int checks = 0;
  int errors = 0;

  // scoreboard of expected {op,data}
  logic [10:0] exp_q[$];
  string       cur_req = "R1";

  // EEPROM model state and configuration
  logic [6:0]  m_tgt;
  bit          m_two, m_inc;
  int          m_pat, m_nack_at;
  int          m_ph;          // 0 idle, 1 addr, 2 ptr1, 3 ptr2, 4 data, 5 read
  logic [15:0] m_ptr;
  bit          m_pend;
  int          m_commits, m_wr_cnt, m_rd_cnt;
  logic [7:0]  m_rd_first;
  bit          m_rd_diff;
  int          dly = 0;

  eeprom_addr_probe dut (
    .clk(clk), .rst_n(rst_n), .start(start), .target_addr(target_addr),
    .legacy_mode(legacy_mode), .busy(busy), .done(done), .two_byte(two_byte),
    .error(error), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .rsp_valid(rsp_valid), .rsp_ack(rsp_ack), .rsp_data(rsp_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] memv(input int pat, input logic [15:0] a);
    case (pat)
      0: return 8'hA5;
      1: return a[7:0] ^ 8'h3C;
      2: return (a == 16'd7) ? 8'h5A : 8'hA5;
      3: return (a == 16'd0) ? 8'h11 : 8'h22;
      default: return 8'h00;
    endcase
  endfunction

  task automatic model(input logic [2:0] op, input logic [7:0] d,
                       output logic ack, output logic [7:0] rd);
    ack = 1'b1;
    rd  = 8'h00;
    case (op)
      C_START, C_RESTART: begin m_pend = 0; m_ph = 1; end
      C_STOP: begin
        if (m_pend) m_commits++;
        m_pend = 0; m_ph = 0;
      end
      C_WRITE: begin
        m_wr_cnt++;
        case (m_ph)
          1: begin ack = (d[7:1] == m_tgt); m_ph = d[0] ? 5 : 2; end
          2: if (m_two) begin m_ptr[15:8] = d; m_ph = 3; end
             else begin m_ptr = {8'h00, d}; m_ph = 4; end
          3: begin m_ptr[7:0] = d; m_ph = 4; end
          4: m_pend = 1;
          default: ack = 1'b0;
        endcase
        if (m_wr_cnt == m_nack_at) ack = 1'b0;
      end
      C_RDACK, C_RDNACK: begin
        rd = memv(m_pat, m_ptr);
        if (m_inc) m_ptr = m_ptr + 16'd1;
        if (m_rd_cnt == 0) m_rd_first = rd;
        else if (rd != m_rd_first) m_rd_diff = 1;
        m_rd_cnt++;
      end
      default: ack = 1'b0;
    endcase
  endtask

  // engine model and scoreboard monitor (R1, R4, R6, R10)
  initial begin : engine
    logic [2:0] c_op;
    logic [7:0] c_data;
    logic       r_ack;
    logic [7:0] r_dat;
    logic [10:0] e;
    forever begin
      @(negedge clk);
      if (cmd_valid) begin
        repeat (dly) @(negedge clk);
        dly = (dly + 1) % 3;
        c_op   = cmd_op;
        c_data = cmd_data;
        cmd_ready = 1'b1;
        @(negedge clk);
        cmd_ready = 1'b0;
        if (exp_q.size() == 0) begin
          chk(cur_req, "unexpected command op", int'(c_op), -1);
        end else begin
          e = exp_q.pop_front();
          chk(cur_req, "command op", int'(c_op), int'(e[10:8]));
          chk(cur_req, "command byte", int'(c_data), int'(e[7:0]));
        end
        model(c_op, c_data, r_ack, r_dat);
        repeat (dly) @(negedge clk);
        rsp_valid = 1'b1;
        rsp_ack   = r_ack;
        rsp_data  = r_dat;
        @(negedge clk);
        rsp_valid = 1'b0;
      end
    end
  end

  task automatic build(input bit leg, input logic [6:0] t, input int nk, output bit aborts);
    logic [10:0] full[$];
    int wc = 0;
    aborts = 0;
    if (!leg) begin
      for (int k = 0; k < 8; k++) begin
        full.push_back({C_START, 8'h00});
        full.push_back({C_WRITE, t, 1'b0});
        full.push_back({C_WRITE, 8'h00});
        full.push_back({C_WRITE, 8'(k)});
        full.push_back({C_RESTART, 8'h00});
        full.push_back({C_WRITE, t, 1'b1});
        full.push_back({C_RDNACK, 8'h00});
        full.push_back({C_STOP, 8'h00});
      end
    end else begin
      full.push_back({C_START, 8'h00});
      full.push_back({C_WRITE, t, 1'b0});
      full.push_back({C_WRITE, 8'h00});
      full.push_back({C_STOP, 8'h00});
      for (int k = 0; k < 8; k++) begin
        full.push_back({C_START, 8'h00});
        full.push_back({C_WRITE, t, 1'b1});
        full.push_back({C_RDNACK, 8'h00});
        full.push_back({C_STOP, 8'h00});
      end
    end
    foreach (full[i]) begin
      exp_q.push_back(full[i]);
      if (full[i][10:8] == C_WRITE) begin
        wc++;
        if (wc == nk) begin
          exp_q.push_back({C_STOP, 8'h00});
          aborts = 1;
          break;
        end
      end
    end
  endtask

  task automatic pulse_start(input bit leg, input logic [6:0] t);
    @(negedge clk);
    legacy_mode = leg;
    target_addr = t;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run(input string req, input bit leg, input logic [6:0] t, input bit two,
                     input bit inc, input int pat, input int nk, input bit poke);
    bit   aborts;
    logic held_two, held_err;
    cur_req = req;
    m_tgt = t; m_two = two; m_inc = inc; m_pat = pat; m_nack_at = nk;
    m_ph = 0; m_ptr = 16'h0000; m_pend = 0; m_commits = 0; m_wr_cnt = 0;
    m_rd_cnt = 0; m_rd_first = 8'h00; m_rd_diff = 0;
    build(leg, t, nk, aborts);
    pulse_start(leg, t);
    chk("R8", "busy after start", int'(busy), 1);
    if (poke) begin
      repeat (15) @(negedge clk);
      chk("R8", "busy mid-run", int'(busy), 1);
      pulse_start(~leg, t ^ 7'h05);  // must be ignored; scoreboard shows it
      legacy_mode = leg;
      target_addr = t;
    end
    do @(negedge clk); while (!done);
    chk("R8", "busy low at done", int'(busy), 0);
    chk(aborts ? "R7" : req, "error flag", int'(error), int'(aborts));
    chk(aborts ? "R7" : "R3", "two_byte result", int'(two_byte), aborts ? 0 : int'(m_rd_diff));
    chk(req, "commands left unissued", exp_q.size(), 0);
    chk("R2", "committed EEPROM writes", m_commits, 0);
    held_two = two_byte;
    held_err = error;
    @(negedge clk);
    chk("R9", "done width", int'(done), 0);
    repeat (4) @(negedge clk);
    chk("R9", "two_byte held", int'(two_byte), int'(held_two));
    chk("R9", "error held", int'(error), int'(held_err));
    chk("R8", "no command while idle", int'(cmd_valid), 0);
    exp_q.delete();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog: actual no done expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9", "reset busy", int'(busy), 0);
    chk("R9", "reset done", int'(done), 0);
    chk("R9", "reset two_byte", int'(two_byte), 0);
    chk("R9", "reset error", int'(error), 0);
    chk("R9", "reset cmd_valid", int'(cmd_valid), 0);

    // R1/R3/R6: one-byte device, varied memory -> pointer stuck at 0 -> 0
    run("R1", 0, 7'h50, 0, 1, 1, 0, 0);
    chk("R3", "one-byte device", int'(two_byte), 0);
    // R3: two-byte device, varied memory
    run("R1", 0, 7'h50, 1, 1, 1, 0, 0);
    chk("R3", "two-byte varied", int'(two_byte), 1);
    // R3: only last location differs, non-incrementing device
    run("R3", 0, 7'h57, 1, 0, 2, 0, 0);
    chk("R3", "last-only mismatch", int'(two_byte), 1);
    // R3: only first location differs
    run("R3", 0, 7'h51, 1, 0, 3, 0, 0);
    chk("R3", "first-only mismatch", int'(two_byte), 1);
    // R5: uniform memory in a two-byte device
    run("R5", 0, 7'h50, 1, 1, 0, 0, 0);
    chk("R5", "uniform two-byte result", int'(two_byte), 0);
    chk("R5", "uniform two-byte error", int'(error), 0);
    // R4: legacy method, incrementing two-byte device
    run("R4", 1, 7'h52, 1, 1, 1, 0, 0);
    chk("R4", "legacy incrementing", int'(two_byte), 1);
    // R4: legacy method on a non-incrementing two-byte device
    run("R4", 1, 7'h52, 1, 0, 1, 0, 0);
    chk("R4", "legacy non-incrementing", int'(two_byte), 0);
    // R7: target absent, refused address byte
    run("R7", 0, 7'h50, 1, 1, 1, 1, 0);
    // R7: refused second pointer byte
    run("R7", 0, 7'h50, 1, 1, 1, 3, 0);
    // R7: refusal in the second probe after one read
    run("R7", 0, 7'h50, 1, 1, 1, 6, 0);
    // R7: legacy, refused pointer byte
    run("R7", 1, 7'h50, 1, 1, 1, 2, 0);
    // R8: start while busy ignored
    run("R8", 0, 7'h53, 1, 1, 1, 0, 1);
    chk("R8", "result after ignored start", int'(two_byte), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule